// File: doc/BRIEF.md
# One-of-Four Serial Word Link

This block moves 32-bit words across a single unidirectional, point-to-point link. It does not use a shared clock or a strobe. Each transfer unit is a symbol that carries two bits. The symbol raises exactly one of four rails, so the rail that is high is itself the data value. Because the code is delay-insensitive, the receiving side learns that a symbol has arrived from the rails themselves. The receiver then answers on a single acknowledge wire. Each symbol completes a four-phase, return-to-zero exchange:

1. The sender drives one rail high.
2. The receiver raises the acknowledge.
3. The sender drops all rails.
4. The receiver drops the acknowledge.

Symbols follow one another as fast as this exchange completes.

The top module contains a transmitter and a receiver. Both sit on the same local clock, and each one passes its incoming link wires through a synchronizer. The link wires are brought out as ports, so the two ends can be wired through any delay, or split across two blocks. The transmitter takes words on a valid/ready interface and cuts each word into pairs, sending the least significant pair first. The receiver rebuilds the word and offers it on a valid/ready interface. The receiver also flags any code in which more than one rail is high.

Top module: `quad_rail_link`

## Requirements
- R1: The transmitter never drives more than one rail high. Every symbol it sends has exactly one rail high.
- R2: A pair of value k (0 to 3) is sent by raising rail bit k. A word of WORD_W bits is sent as WORD_W/2 symbols, starting with bits [1:0] and ending with the most significant pair.
- R3: The transmitter holds a symbol until it sees the acknowledge high. It then drives all rails low. It raises the next symbol only after the acknowledge has gone low again. A rail never changes from one non-zero code straight to another.
- R4: The receiver raises the acknowledge only after its synchronized rails show exactly one high rail. It lowers the acknowledge only after its synchronized rails are all low. No other signal marks data arrival.
- R5: `tx_ready` is high after reset and while the transmitter is idle. It is low from the moment a word is accepted until that word's transfer has finished.
- R6: The transmitter accepts a new word only when the acknowledge of the last symbol of the previous word has returned low.
- R7: When the received rails show two or more high rails, `rx_clash` goes high within SYNC_STAGES+2 cycles. The receiver does not acknowledge that code and takes no data from it. `rx_clash` returns low once the rails are valid or null again.
- R8: While `rx_valid` is high and `rx_ready` is low, `rx_valid` stays high and `rx_word` does not change. While the output slot is occupied, the receiver holds the last symbol's acknowledge high, so no word is lost.
- R9: Words arrive in order and unchanged for any fixed delay on the forward rails and on the acknowledge wire.
- R10: During reset and directly after it, all outgoing rails are low, the acknowledge is low, and `rx_valid` and `rx_clash` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock for both ends |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Word offered to the transmitter |
| tx_ready | output | 1 | Transmitter idle and able to accept a word |
| tx_word | input | WORD_W | Word to send |
| line_rail_o | output | 4 | Rails driven toward the far end |
| line_ack_i | input | 1 | Acknowledge returning from the far end |
| line_rail_i | input | 4 | Rails arriving from the far end |
| line_ack_o | output | 1 | Acknowledge sent back to the far end |
| rx_valid | output | 1 | Reassembled word available |
| rx_ready | input | 1 | Consumer takes the word |
| rx_word | output | WORD_W | Reassembled word |
| rx_clash | output | 1 | More than one received rail is high |

## Verification
The bench builds the block with its defaults: WORD_W=32 and SYNC_STAGES=2. This makes every word sixteen symbols long, so the symbol counter runs all the way to its last value and wraps back to zero. A delay line inside the bench shifts the forward rails and the acknowledge by 0 to 7 cycles in each direction. The delays are chosen independently, which puts both the fast and the slow ordering of the handshake within reach. Paced consumer stalls force the receiver to hold its final acknowledge. Forced multi-hot codes on an idle link exercise the clash path.

// File: rtl/qlink_pkg.sv
package qlink_pkg;

    typedef logic [3:0] rail_t;
    typedef logic [1:0] pair_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_DRIVE,
        TX_RETURN
    } tx_state_e;

    typedef enum logic {
        RX_WAIT_CODE,
        RX_WAIT_NULL
    } rx_state_e;

    // Rail k high carries pair value k.
    function automatic rail_t pair_to_rail(pair_t p);
        rail_t r;
        r = '0;
        r[p] = 1'b1;
        return r;
    endfunction

    function automatic pair_t rail_to_pair(rail_t r);
        pair_t p;
        p = '0;
        for (int i = 0; i < 4; i++) begin
            if (r[i]) p = pair_t'(i);
        end
        return p;
    endfunction

    function automatic logic rail_is_null(rail_t r);
        return (r == '0);
    endfunction

    function automatic logic rail_is_code(rail_t r);
        return (r != '0) && ((r & (r - 4'd1)) == '0);
    endfunction

    function automatic logic rail_is_clash(rail_t r);
        return (r != '0) && ((r & (r - 4'd1)) != '0);
    endfunction

endpackage

// File: rtl/qlink_sync.sv
module qlink_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int N = (STAGES < 1) ? 1 : STAGES;

    logic [W-1:0] chain [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < N; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[N-1];
endmodule

// File: rtl/qlink_tx.sv
module qlink_tx
    import qlink_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output rail_t             rail_o,
    input  logic              ack_i
);
    localparam int NSYM  = WORD_W / 2;
    localparam int IDX_W = (NSYM > 1) ? $clog2(NSYM) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NSYM - 1);

    tx_state_e          state;
    logic [WORD_W-1:0]  shreg;
    logic [IDX_W-1:0]   idx;
    rail_t              rail_q;
    logic               ack_s;

    qlink_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (ack_i),
        .q   (ack_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TX_IDLE;
            shreg  <= '0;
            idx    <= '0;
            rail_q <= '0;
        end else begin
            unique case (state)
                TX_IDLE: begin
                    if (in_valid) begin
                        shreg  <= in_data;
                        idx    <= '0;
                        rail_q <= pair_to_rail(in_data[1:0]);
                        state  <= TX_DRIVE;
                    end
                end
                TX_DRIVE: begin
                    if (ack_s) begin
                        rail_q <= '0;
                        state  <= TX_RETURN;
                    end
                end
                TX_RETURN: begin
                    if (!ack_s) begin
                        if (idx == LAST) begin
                            state <= TX_IDLE;
                        end else begin
                            idx    <= idx + 1'b1;
                            rail_q <= pair_to_rail(shreg[3:2]);
                            shreg  <= shreg >> 2;
                            state  <= TX_DRIVE;
                        end
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    assign in_ready = (state == TX_IDLE);
    assign rail_o   = rail_q;

    AST_TX_ONE_RAIL: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rail_o)); // R1
    AST_TX_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
        (rail_o != '0 && !ack_s) |=> $stable(rail_o)); // R3
    AST_TX_NULL_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        (rail_o != '0) |=> (rail_o == $past(rail_o) || rail_o == '0)); // R3
    AST_TX_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (rail_o == '0 && !ack_s)); // R6
endmodule

// File: rtl/qlink_rx.sv
module qlink_rx
    import qlink_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  rail_t             rail_i,
    output logic              ack_o,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              clash_o
);
    localparam int NSYM  = WORD_W / 2;
    localparam int IDX_W = (NSYM > 1) ? $clog2(NSYM) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NSYM - 1);

    rx_state_e          state;
    rail_t              rail_s;
    logic [WORD_W-1:0]  acc;
    logic [IDX_W-1:0]   idx;
    logic               ack_q;
    logic               ov_q;
    logic [WORD_W-1:0]  od_q;
    logic               clash_q;
    logic               slot_free;

    qlink_sync #(.W(4), .STAGES(SYNC_STAGES)) u_rail_sync (
        .clk (clk),
        .rst (rst),
        .d   (rail_i),
        .q   (rail_s)
    );

    assign slot_free = !ov_q || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_WAIT_CODE;
            acc     <= '0;
            idx     <= '0;
            ack_q   <= 1'b0;
            ov_q    <= 1'b0;
            od_q    <= '0;
            clash_q <= 1'b0;
        end else begin
            clash_q <= rail_is_clash(rail_s);
            if (ov_q && out_ready) ov_q <= 1'b0;
            unique case (state)
                RX_WAIT_CODE: begin
                    if (rail_is_code(rail_s)) begin
                        acc   <= {rail_to_pair(rail_s), acc[WORD_W-1:2]};
                        ack_q <= 1'b1;
                        state <= RX_WAIT_NULL;
                    end
                end
                RX_WAIT_NULL: begin
                    if (rail_is_null(rail_s)) begin
                        if (idx != LAST) begin
                            idx   <= idx + 1'b1;
                            ack_q <= 1'b0;
                            state <= RX_WAIT_CODE;
                        end else if (slot_free) begin
                            idx   <= '0;
                            od_q  <= acc;
                            ov_q  <= 1'b1;
                            ack_q <= 1'b0;
                            state <= RX_WAIT_CODE;
                        end
                    end
                end
                default: state <= RX_WAIT_CODE;
            endcase
        end
    end

    assign ack_o     = ack_q;
    assign out_valid = ov_q;
    assign out_data  = od_q;
    assign clash_o   = clash_q;

    AST_RX_ACK_ON_CODE: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_o) |-> $past(rail_is_code(rail_s))); // R4
    AST_RX_DROP_ON_NULL: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_o) |-> $past(rail_is_null(rail_s))); // R4
    AST_RX_NO_ACK_CLASH: assert property (@(posedge clk) disable iff (rst)
        (rail_is_clash(rail_s) && !ack_o) |=> !ack_o); // R7
    AST_RX_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
endmodule

// File: rtl/quad_rail_link.sv
module quad_rail_link
    import qlink_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [WORD_W-1:0] tx_word,
    output logic [3:0]        line_rail_o,
    input  logic              line_ack_i,
    input  logic [3:0]        line_rail_i,
    output logic              line_ack_o,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_clash
);
    rail_t tx_rail;

    qlink_tx #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .in_valid (tx_valid),
        .in_ready (tx_ready),
        .in_data  (tx_word),
        .rail_o   (tx_rail),
        .ack_i    (line_ack_i)
    );

    qlink_rx #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .rail_i    (rail_t'(line_rail_i)),
        .ack_o     (line_ack_o),
        .out_valid (rx_valid),
        .out_ready (rx_ready),
        .out_data  (rx_word),
        .clash_o   (rx_clash)
    );

    assign line_rail_o = tx_rail;

    AST_LINK_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (line_rail_o == '0 && !line_ack_o && !rx_valid && !rx_clash)); // R10
endmodule

// File: tb/sim_quad_rail_link.sv
`timescale 1ns/1ps
module sim_quad_rail_link;
    localparam int WORD_W = 32;
    localparam int NSYM   = WORD_W / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic              tx_valid = 1'b0;
    logic              tx_ready;
    logic [WORD_W-1:0] tx_word  = '0;
    logic [3:0]        line_rail_o;
    logic              ack_to_tx;
    logic [3:0]        rail_to_rx;
    logic              line_ack_o;
    logic              rx_valid;
    logic              rx_ready = 1'b1;
    logic [WORD_W-1:0] rx_word;
    logic              rx_clash;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // link model: independent delays, plus forced codes
    logic [3:0] fwd_pipe [8];
    logic       bwd_pipe [8];
    int         fwd_dly = 0;
    int         bwd_dly = 0;
    logic       inj_en  = 1'b0;
    logic [3:0] inj_val = 4'b0000;
    bit         stall_mode = 0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) begin
                fwd_pipe[i] <= '0;
                bwd_pipe[i] <= 1'b0;
            end
        end else begin
            fwd_pipe[0] <= line_rail_o;
            bwd_pipe[0] <= line_ack_o;
            for (int i = 1; i < 8; i++) begin
                fwd_pipe[i] <= fwd_pipe[i-1];
                bwd_pipe[i] <= bwd_pipe[i-1];
            end
        end
    end

    assign rail_to_rx = inj_en ? inj_val : ((fwd_dly == 0) ? line_rail_o : fwd_pipe[fwd_dly-1]);
    assign ack_to_tx  = (bwd_dly == 0) ? line_ack_o : bwd_pipe[bwd_dly-1];

    quad_rail_link #(.WORD_W(WORD_W), .SYNC_STAGES(2)) u0 (
        .clk         (clk),
        .rst         (rst),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .tx_word     (tx_word),
        .line_rail_o (line_rail_o),
        .line_ack_i  (ack_to_tx),
        .line_rail_i (rail_to_rx),
        .line_ack_o  (line_ack_o),
        .rx_valid    (rx_valid),
        .rx_ready    (rx_ready),
        .rx_word     (rx_word),
        .rx_clash    (rx_clash)
    );

    logic [WORD_W-1:0] word_q [$];
    logic [1:0]        pair_q [$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // driver: push expectations, then offer the word
    task automatic send_word(input logic [WORD_W-1:0] w);
        word_q.push_back(w);
        for (int i = 0; i < NSYM; i++) pair_q.push_back(w[2*i +: 2]);
        @(posedge clk) #1;
        tx_valid = 1'b1;
        tx_word  = w;
        forever begin
            @(negedge clk);
            if (tx_ready) break;
        end
        @(posedge clk) #1;
        tx_valid = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while ((word_q.size() != 0 || !tx_ready || line_ack_o) && n < 30000) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
    endtask

    // consumer pacing
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk) #1;
            cyc++;
            rx_ready = !stall_mode || ((cyc % 23) < 3);
        end
    end

    // symbol monitor on the transmit rails
    initial begin
        logic [3:0] prev = 4'b0000;
        logic [1:0] ep;
        forever begin
            @(negedge clk);
            if (rst) begin
                prev = 4'b0000;
                continue;
            end
            if (line_rail_o != prev) begin
                if (prev == 4'b0000) begin
                    check($countones(line_rail_o) == 1, "R1", "symbol rail count",
                          64'($countones(line_rail_o)), 64'd1);
                    check(ack_to_tx == 1'b0, "R3", "new symbol while ack high",
                          64'(ack_to_tx), 64'd0);
                    check(tx_ready == 1'b0, "R5", "ready during transfer",
                          64'(tx_ready), 64'd0);
                    if (pair_q.size() == 0) begin
                        check(1'b0, "R2", "unexpected symbol", 64'(line_rail_o), 64'd0);
                    end else begin
                        ep = pair_q.pop_front();
                        check(line_rail_o == (4'b0001 << ep), "R2", "pair to rail code",
                              64'(line_rail_o), 64'(4'b0001 << ep));
                    end
                end else begin
                    check(line_rail_o == 4'b0000, "R3", "code changed without null",
                          64'(line_rail_o), 64'd0);
                    check(ack_to_tx == 1'b1, "R3", "null before ack",
                          64'(ack_to_tx), 64'd1);
                end
            end
            prev = line_rail_o;
        end
    end

    // acceptance monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && tx_valid && tx_ready)
                check(ack_to_tx == 1'b0, "R6", "accepted with ack high",
                      64'(ack_to_tx), 64'd0);
        end
    end

    // word scoreboard
    initial begin
        bit stalled = 0;
        logic [WORD_W-1:0] held = '0;
        logic [WORD_W-1:0] ew;
        forever begin
            @(negedge clk);
            if (rst) begin
                stalled = 0;
                continue;
            end
            if (stalled)
                check(rx_valid && rx_word == held, "R8", "held output changed",
                      64'(rx_word), 64'(held));
            if (rx_valid && rx_ready) begin
                stalled = 0;
                if (word_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected word", 64'(rx_word), 64'd0);
                end else begin
                    ew = word_q.pop_front();
                    check(rx_word == ew, "R9", "received word", 64'(rx_word), 64'(ew));
                end
            end else if (rx_valid) begin
                stalled = 1;
                held    = rx_word;
            end else begin
                stalled = 0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R9 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    task automatic clash_probe(input logic [3:0] code);
        bit saw_clash = 0;
        bit saw_ack   = 0;
        @(posedge clk) #1;
        inj_en  = 1'b1;
        inj_val = code;
        repeat (10) begin
            @(negedge clk);
            if (rx_clash)   saw_clash = 1;
            if (line_ack_o) saw_ack   = 1;
        end
        check(saw_clash, "R7", "clash flag", 64'(saw_clash), 64'd1);
        check(!saw_ack, "R7", "ack on clash", 64'(saw_ack), 64'd0);
        @(posedge clk) #1;
        inj_en  = 1'b0;
        inj_val = 4'b0000;
        repeat (6) @(negedge clk);
        check(rx_clash == 1'b0, "R7", "clash clears", 64'(rx_clash), 64'd0);
    endtask

    initial begin
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(line_rail_o == 4'b0000, "R10", "reset rails", 64'(line_rail_o), 64'd0);
        check(line_ack_o == 1'b0, "R10", "reset ack", 64'(line_ack_o), 64'd0);
        check(rx_valid == 1'b0, "R10", "reset valid", 64'(rx_valid), 64'd0);
        check(rx_clash == 1'b0, "R10", "reset clash", 64'(rx_clash), 64'd0);
        check(tx_ready == 1'b1, "R5", "ready in reset", 64'(tx_ready), 64'd1);
        @(posedge clk) #1;
        rst = 1'b0;
        @(negedge clk);
        check(tx_ready == 1'b1, "R5", "ready after reset", 64'(tx_ready), 64'd1);
        check(line_rail_o == 4'b0000, "R10", "rails after reset", 64'(line_rail_o), 64'd0);

        // no delay, edge patterns
        send_word(32'h0000_0000);
        send_word(32'hFFFF_FFFF);
        send_word(32'h1B1B_1B1B);
        send_word(32'h8000_0001);
        send_word(32'hE4E4_E4E4);
        drain();
        check(tx_ready == 1'b1, "R5", "ready when idle", 64'(tx_ready), 64'd1);

        // asymmetric delays
        fwd_dly = 3; bwd_dly = 5;
        send_word(32'hDEAD_BEEF);
        send_word(32'h0123_4567);
        send_word(32'hC000_0003);
        drain();

        // slow forward path, consumer stalls
        fwd_dly = 7; bwd_dly = 2; stall_mode = 1;
        send_word(32'hA5A5_5A5A);
        send_word(32'h7FFF_FFFE);
        send_word(32'h3C3C_C3C3);
        send_word(32'h0F0F_F0F0);
        drain();
        stall_mode = 0;

        // multi-hot codes on an idle link are ignored
        fwd_dly = 0; bwd_dly = 0;
        clash_probe(4'b0101);
        clash_probe(4'b1111);
        check(rx_valid == 1'b0, "R7", "no word from clash", 64'(rx_valid), 64'd0);
        send_word(32'h2468_ACE0);
        send_word(32'h1357_9BDF);
        drain();

        check(word_q.size() == 0, "R9", "words outstanding", 64'(word_q.size()), 64'd0);
        check(pair_q.size() == 0, "R2", "symbols outstanding", 64'(pair_q.size()), 64'd0);
        finish_run();
    end
endmodule